// File: doc/BRIEF.md
# Serial Frequency Word Receiver

This block takes a 16-bit tone frequency increment from a three-wire serial link (data, shift clock, load strobe). The serial lines are asynchronous to the system clock; the block synchronizes them and acts only on their edges. Each rising shift-clock edge moves one data bit into a shift register. Each falling strobe edge copies the shift register into an output register, so the word the downstream phase accumulator uses changes only at a load.

An all-zero detector watches the shift register. Together with a strobe held high and a 2-bit encoded mode input, it turns the "load a zero word" gesture into a power-down or an inhibit request. The power-down case also has a forced variant, selected by the mode input alone. The receive path keeps working in every mode.

Top module: `freq_word_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `freq_inc_o` is 0 and `pwr_dn_o` and `inh_req_o` are 0.
- R2: Each rising edge of `ser_clk_i` shifts `ser_dat_i` into the shift register, least significant bit first. After 16 rising edges, the register holds the word whose bit 0 was sent first.
- R3: Shifting bits without a falling strobe edge leaves `freq_inc_o` unchanged (double buffering).
- R4: `freq_inc_o` is loaded from the shift register only on a falling edge of `ser_lat_i`. A rising edge, or a strobe held high, leaves it unchanged.
- R5: With `mode_i` = 2'b00 (low level), `pwr_dn_o` is 1 whatever the shift register holds and whatever the strobe level.
- R6: With `mode_i` = 2'b10 or 2'b11 (high level), `pwr_dn_o` is 1 exactly when the shift register is all zeros and the synchronized strobe is high. Otherwise it is 0.
- R7: With `mode_i` = 2'b01 (middle level), `inh_req_o` is 1 exactly when the shift register is all zeros and the synchronized strobe is high. In every other mode it is 0.
- R8: In power-down, words are still shifted and loaded into `freq_inc_o`.
- R9: `pwr_dn_o` and `inh_req_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial shift clock |
| ser_dat_i | input | 1 | Asynchronous serial data |
| ser_lat_i | input | 1 | Asynchronous load strobe |
| mode_i | input | 2 | Encoded mode: 00 low, 01 middle, 10/11 high |
| freq_inc_o | output | 16 | Loaded frequency increment |
| pwr_dn_o | output | 1 | Power-down request |
| inh_req_o | output | 1 | Inhibit request |

## Verification
A wrong bit order or a lost shift edge only shows at the next falling strobe edge, about three system cycles later, as a wrong or bit-reversed `freq_inc_o`. A zero detector stuck at either value shows as a missing or spurious mode flag within three cycles of the strobe rising. A load that fires on the wrong strobe edge shows as `freq_inc_o` changing while the strobe is still high. The bench samples at each of these points.

// File: rtl/freq_word_rx_pkg.sv
package freq_word_rx_pkg;
  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_MID  = 2'b01,
    MODE_HIGH = 2'b10,
    MODE_HI2  = 2'b11
  } mode_e;
endpackage

// File: rtl/fwr_sync.sv
module fwr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1, s2, s3;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign lvl_o  = s2;
  assign prev_o = s3;
endmodule

// File: rtl/fwr_shift.sv
module fwr_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o,
  output logic         zero_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (en_i) q <= {bit_i, q[W-1:1]};
  end
  assign q_o    = q;
  assign zero_o = (q == '0);
endmodule

// File: rtl/fwr_mode.sv
module fwr_mode
  import freq_word_rx_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       zero_i,
  input  logic       lat_i,
  output logic       pd_o,
  output logic       inh_o
);
  logic armed;
  assign armed = zero_i & lat_i;
  always_comb begin
    pd_o  = 1'b0;
    inh_o = 1'b0;
    case (mode_e'(mode_i))
      MODE_LOW:  pd_o  = 1'b1;
      MODE_MID:  inh_o = armed;
      default:   pd_o  = armed;
    endcase
  end
endmodule

// File: rtl/freq_word_rx.sv
module freq_word_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_lat_i,
  input  logic [1:0]        mode_i,
  output logic [WORD_W-1:0] freq_inc_o,
  output logic              pwr_dn_o,
  output logic              inh_req_o
);
  localparam int NSYNC = 3;
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LAT = 2;

  logic [NSYNC-1:0] lvl, prev;
  logic             sck_rise, lat_fall, zero, pd_nxt, inh_nxt;
  logic [WORD_W-1:0] shreg;

  fwr_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({ser_lat_i, ser_dat_i, ser_clk_i}),
    .lvl_o(lvl), .prev_o(prev)
  );

  assign sck_rise = lvl[IDX_CLK] & ~prev[IDX_CLK];
  assign lat_fall = ~lvl[IDX_LAT] & prev[IDX_LAT];

  fwr_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .en_i(sck_rise), .bit_i(lvl[IDX_DAT]),
    .q_o(shreg), .zero_o(zero)
  );

  fwr_mode u_mode (
    .mode_i(mode_i), .zero_i(zero), .lat_i(lvl[IDX_LAT]),
    .pd_o(pd_nxt), .inh_o(inh_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_inc_o <= '0;
      pwr_dn_o   <= 1'b0;
      inh_req_o  <= 1'b0;
    end else begin
      if (lat_fall) freq_inc_o <= shreg;
      pwr_dn_o  <= pd_nxt;
      inh_req_o <= inh_nxt;
    end
  end
endmodule

// File: rtl/freq_word_rx_chk.sv
module freq_word_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_i,
  input logic [WORD_W-1:0] freq_inc_o,
  input logic              pwr_dn_o,
  input logic              inh_req_o,
  input logic              lat_fall,
  input logic [WORD_W-1:0] shreg
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (freq_inc_o == '0 && !pwr_dn_o && !inh_req_o));
  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    lat_fall |=> (freq_inc_o == $past(shreg)));
  // R3
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !lat_fall |=> $stable(freq_inc_o));
  // R5
  forced_pd_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |=> pwr_dn_o);
  // R9
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(pwr_dn_o && inh_req_o));
endmodule

bind freq_word_rx freq_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .freq_inc_o(freq_inc_o),
  .pwr_dn_o(pwr_dn_o), .inh_req_o(inh_req_o),
  .lat_fall(lat_fall), .shreg(shreg)
);

// File: tb/freq_word_rx_tb.sv
module freq_word_rx_tb;
  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_dat = 0, ser_lat = 0;
  logic [1:0] mode = 2'b10;
  logic [15:0] freq;
  logic pd, inh;
  int total = 0, bad = 0;
  logic [15:0] exp_out = 0;
  logic [15:0] exp_sr = 0;

  always #2.5 clk = ~clk;

  freq_word_rx u_dut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_lat_i(ser_lat), .mode_i(mode), .freq_inc_o(freq),
    .pwr_dn_o(pd), .inh_req_o(inh)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_pd(logic [1:0] m, logic [15:0] sr, logic lat);
    return (m == 2'b00) || (m[1] && sr == 0 && lat);
  endfunction

  function automatic logic exp_inh(logic [1:0] m, logic [15:0] sr, logic lat);
    return (m == 2'b01) && sr == 0 && lat;
  endfunction

  task automatic put_bit(logic b);
    ser_dat = b; tick(2);
    ser_clk = 1; tick(4);
    ser_clk = 0; tick(4);
  endtask

  task automatic shift_word(logic [15:0] w);
    for (int i = 0; i < 16; i++) put_bit(w[i]);
    exp_sr = w;
  endtask

  task automatic lat_high;
    ser_lat = 1; tick(5);
  endtask

  task automatic lat_low;
    ser_lat = 0; tick(5);
    exp_out = exp_sr;
  endtask

  task automatic chk_flags(string req);
    chk(req, {15'd0, pd}, {15'd0, exp_pd(mode, exp_sr, ser_lat)});
    chk(req, {15'd0, inh}, {15'd0, exp_inh(mode, exp_sr, ser_lat)});
  endtask

  initial begin
    tick(2000000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    tick(3);
    // R1 reset state
    chk("R1", freq, 16'h0);
    chk("R1", {14'd0, pd, inh}, 16'h0);
    rst = 0; tick(1);
    chk("R1", {14'd0, pd, inh}, 16'h0);
    tick(3);

    // R2 random words, LSB first
    for (int k = 0; k < 12; k++) begin
      logic [15:0] w;
      w = 16'($urandom()) | 16'h1;
      shift_word(w);
      lat_high; chk_flags("R6");
      lat_low;
      chk("R2", freq, w);
    end

    // R3 shift without load
    shift_word(16'hA5C3);
    chk("R3", freq, exp_out);
    // R4 strobe high does not load
    mode = 2'b01;
    lat_high;
    chk("R4", freq, exp_out == 16'hA5C3 ? 16'h0 : exp_out);
    chk_flags("R7");
    lat_low;
    chk("R4", freq, 16'hA5C3);

    // R7 inhibit with zero word
    shift_word(16'h0);
    lat_high; chk_flags("R7");
    chk("R7", {15'd0, inh}, 16'h1);
    lat_low; chk_flags("R7");
    chk("R4", freq, 16'h0);

    // R6 high level, both encodings
    for (int m = 2; m < 4; m++) begin
      mode = 2'(m);
      tick(3);
      lat_high; chk_flags("R6");
      chk("R6", {15'd0, pd}, 16'h1);
      lat_low; chk_flags("R6");
    end
    // R6 nonzero word prevents power-down
    shift_word(16'h8000);
    lat_high; chk_flags("R6");
    chk("R6", {15'd0, pd}, 16'h0);
    lat_low;

    // R5 forced power-down, R8 loading still works
    mode = 2'b00; tick(3);
    chk("R5", {15'd0, pd}, 16'h1);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] w;
      w = 16'($urandom());
      shift_word(w);
      lat_high; chk("R5", {15'd0, pd}, 16'h1);
      lat_low;
      chk("R8", freq, w);
      chk("R9", {15'd0, inh}, 16'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule